// File: doc/BRIEF.md
# Stream-Mode Card Write Transmitter

This block moves an unbounded or counted run of write bytes from a host-side FIFO onto one data line of a memory-card bus. It reads bytes from a show-ahead FIFO, shifts each one out most significant bit first, and drives a card clock enable that is high exactly in the cycles that carry a data bit. When the FIFO runs dry the clock enable drops and the bit position is held, so the card sees a paused clock and no gap in the data.

A transfer starts with a `start` pulse while the transfer-mode bit selects stream operation. A byte count of zero gives an open-ended stream that runs until the command path reports the end bit of a stop command. A nonzero count limits how many bytes are read. With auto-stop enabled, the block pulses a load request to the command path a fixed number of bits before the last data bit, so that the stop command's end bit can land on the stream's tail. Whichever stop arrives, it is aligned by letting exactly two more enabled bit cycles pass after it, and then the transfer ends with a done pulse.

Top module: `stx_stream_tx`

## Requirements
- R1: A `start` pulse taken while `stream_mode` is 0 is ignored: `busy` stays 0 and `fifo_pop` stays 0.
- R2: Each byte read from the FIFO is sent on `dat_out` most significant bit first. `card_clk_en` is high in exactly the cycles that carry a data bit. The bit sequence equals the FIFO byte sequence.
- R3: While the FIFO is empty and the shift register has run out, `card_clk_en` is 0. Sending resumes when data returns, and no bit is lost or repeated.
- R4: In a cycle where `stop_end` is 1 and the block is running, no further byte is read. At most two further enabled bits follow, in the cycle of `stop_end` and the one after it. Then `busy` falls and `done` is high for exactly one cycle.
- R5: With a nonzero `byte_count` (latched at start), exactly that many bytes are read. After the last bit, `card_clk_en` stays 0 until `stop_end` arrives.
- R6: With a nonzero count and `auto_stop_en`=1, `stop_load` pulses once. It appears together with the data bit that leaves STOP_LEAD bits still to send, or in the first running cycle if the total is at most STOP_LEAD. Clock-gated cycles do not advance this count.
- R7: With `byte_count`=0 or `auto_stop_en`=0, `stop_load` never pulses.
- R8: A `stop_end` that arrives before a counted transfer is exhausted ends it early, following the rule in R4.
- R9: After reset, `busy`, `done`, `card_clk_en`, `stop_load` and `fifo_pop` are 0. A `start` taken while busy is ignored, including its new count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a transfer (taken only when idle) |
| stream_mode | input | 1 | Transfer-mode bit; 1 selects stream operation |
| byte_count | input | CNT_W | Bytes to send; 0 means open-ended |
| auto_stop_en | input | 1 | Let the block request the stop command itself |
| fifo_empty | input | 1 | FIFO has no byte available |
| fifo_data | input | BYTE_W | Head byte of the show-ahead FIFO |
| stop_end | input | 1 | Command path marks the stop command's end bit |
| fifo_pop | output | 1 | Consume the FIFO head byte this cycle |
| card_clk_en | output | 1 | Card clock enable, high for each data bit |
| dat_out | output | 1 | Serial data line |
| stop_load | output | 1 | One-cycle request to load a stop command |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle pulse at transfer end |

## Verification
The hardest situation to reach is an underflow in the middle of a counted auto-stop transfer. In that case the clock gating must also freeze the remaining-bit count, so that `stop_load` still lands on the right bit. The stimulus forces the bench FIFO empty for many cycles part way through a byte run. It then checks that the stop request shows up after the same number of delivered bits as in a run without the gap. The bench reconstructs the bit stream only from cycles with the clock enable high. This shows both the lost-bit and the two-bit stop alignment rules.

// File: rtl/stx_pkg.sv
package stx_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_DRAIN = 2'd2
  } stx_state_t;
endpackage

// File: rtl/stx_ctrl.sv
module stx_ctrl
  import stx_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic       stream_mode,
  input  logic       stop_end,
  output logic       accept,
  output logic       running,
  output logic       active,
  output logic       idle,
  output logic       busy,
  output logic       done
);
  stx_state_t st;
  logic       tail;

  assign accept  = start && stream_mode && (st == ST_IDLE);
  assign running = (st == ST_RUN);
  assign idle    = (st == ST_IDLE);
  // two enabled bit cycles after the stop end bit: the stop cycle and one more
  assign active  = running || ((st == ST_DRAIN) && tail);

  always_ff @(posedge clk) begin
    if (rst) begin
      st   <= ST_IDLE;
      tail <= 1'b0;
      busy <= 1'b0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (accept) begin
            st   <= ST_RUN;
            busy <= 1'b1;
          end
        end
        ST_RUN: begin
          if (stop_end) begin
            st   <= ST_DRAIN;
            tail <= 1'b1;
          end
        end
        ST_DRAIN: begin
          if (tail) begin
            tail <= 1'b0;
          end else begin
            st   <= ST_IDLE;
            busy <= 1'b0;
            done <= 1'b1;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/stx_shifter.sv
module stx_shifter #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              active,
  input  logic              allow_load,
  input  logic              fifo_empty,
  input  logic [BYTE_W-1:0] fifo_data,
  output logic              fifo_pop,
  output logic              bit_sent,
  output logic              dat_out,
  output logic              clk_en
);
  localparam int IW = (BYTE_W > 1) ? $clog2(BYTE_W) : 1;
  localparam logic [IW-1:0] LAST = IW'(BYTE_W - 1);

  logic [BYTE_W-1:0] sh;
  logic [IW-1:0]     idx;
  logic              sh_valid;
  logic              want;

  assign want     = !sh_valid || (active && idx == LAST);
  assign fifo_pop = want && allow_load && !fifo_empty;
  assign bit_sent = sh_valid && active;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      sh       <= '0;
      idx      <= '0;
      sh_valid <= 1'b0;
      clk_en   <= 1'b0;
      if (rst) dat_out <= 1'b0;
    end else begin
      clk_en <= bit_sent;
      if (bit_sent) begin
        dat_out <= sh[BYTE_W-1];
        sh      <= sh << 1;
        idx     <= idx + 1'b1;
        if (idx == LAST) sh_valid <= 1'b0;
      end
      if (fifo_pop) begin
        sh       <= fifo_data;
        idx      <= '0;
        sh_valid <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/stx_counter.sv
module stx_counter #(
  parameter int CNT_W     = 16,
  parameter int BYTE_W    = 8,
  parameter int STOP_LEAD = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] byte_count,
  input  logic             auto_en,
  input  logic             running,
  input  logic             pop,
  input  logic             bit_sent,
  output logic             more_ok,
  output logic             stop_load
);
  localparam int BW = CNT_W + $clog2(BYTE_W) + 1;

  logic             counted;
  logic             auto_q;
  logic             issued;
  logic [CNT_W-1:0] pops_left;
  logic [BW-1:0]    bits_left;
  logic [BW-1:0]    bits_next;

  assign more_ok   = !counted || (pops_left != '0);
  assign bits_next = bits_left - BW'(counted && bit_sent);

  always_ff @(posedge clk) begin
    if (rst) begin
      counted   <= 1'b0;
      auto_q    <= 1'b0;
      issued    <= 1'b0;
      pops_left <= '0;
      bits_left <= '0;
      stop_load <= 1'b0;
    end else if (load) begin
      counted   <= (byte_count != '0);
      auto_q    <= auto_en;
      issued    <= 1'b0;
      pops_left <= byte_count;
      bits_left <= BW'(byte_count) * BW'(BYTE_W);
      stop_load <= 1'b0;
    end else begin
      if (pop && counted) pops_left <= pops_left - 1'b1;
      bits_left <= bits_next;
      if (running && counted && auto_q && !issued && bits_next <= BW'(STOP_LEAD)) begin
        stop_load <= 1'b1;
        issued    <= 1'b1;
      end else begin
        stop_load <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/stx_stream_tx.sv
module stx_stream_tx #(
  parameter int CNT_W     = 16,
  parameter int BYTE_W    = 8,
  parameter int STOP_LEAD = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              stream_mode,
  input  logic [CNT_W-1:0]  byte_count,
  input  logic              auto_stop_en,
  input  logic              fifo_empty,
  input  logic [BYTE_W-1:0] fifo_data,
  input  logic              stop_end,
  output logic              fifo_pop,
  output logic              card_clk_en,
  output logic              dat_out,
  output logic              stop_load,
  output logic              busy,
  output logic              done
);
  logic accept, running, active, idle;
  logic more_ok, bit_sent, allow_load;

  stx_ctrl u_ctrl (
    .clk(clk), .rst(rst), .start(start), .stream_mode(stream_mode),
    .stop_end(stop_end), .accept(accept), .running(running),
    .active(active), .idle(idle), .busy(busy), .done(done)
  );

  assign allow_load = running && !stop_end && more_ok;

  stx_shifter #(.BYTE_W(BYTE_W)) u_shift (
    .clk(clk), .rst(rst), .clear(idle), .active(active),
    .allow_load(allow_load), .fifo_empty(fifo_empty), .fifo_data(fifo_data),
    .fifo_pop(fifo_pop), .bit_sent(bit_sent), .dat_out(dat_out),
    .clk_en(card_clk_en)
  );

  stx_counter #(.CNT_W(CNT_W), .BYTE_W(BYTE_W), .STOP_LEAD(STOP_LEAD)) u_cnt (
    .clk(clk), .rst(rst), .load(accept), .byte_count(byte_count),
    .auto_en(auto_stop_en), .running(running), .pop(fifo_pop),
    .bit_sent(bit_sent), .more_ok(more_ok), .stop_load(stop_load)
  );
endmodule

// File: rtl/stx_stream_tx_chk.sv
module stx_stream_tx_chk (
  input logic clk,
  input logic rst,
  input logic start,
  input logic stream_mode,
  input logic fifo_empty,
  input logic fifo_pop,
  input logic card_clk_en,
  input logic stop_load,
  input logic busy,
  input logic done
);
  // R2/R3: a byte is only taken when one is present
  a_r3_pop_needs_data: assert property (@(posedge clk) disable iff (rst)
    fifo_pop |-> !fifo_empty);
  // R4: done is a single-cycle pulse and coincides with idle
  a_r4_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  a_r4_done_idle: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
  // R6: stop request never lasts two cycles
  a_r6_stop_load_single: assert property (@(posedge clk) disable iff (rst)
    stop_load |=> !stop_load);
  // R9: nothing moves while idle
  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!card_clk_en && !fifo_pop && !stop_load));
  // R1: a transfer only begins after a stream-mode start
  a_r1_start_mode: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> ($past(start) && $past(stream_mode)));
endmodule

bind stx_stream_tx stx_stream_tx_chk i_chk (
  .clk(clk), .rst(rst), .start(start), .stream_mode(stream_mode),
  .fifo_empty(fifo_empty), .fifo_pop(fifo_pop), .card_clk_en(card_clk_en),
  .stop_load(stop_load), .busy(busy), .done(done)
);

// File: tb/test_stx_stream_tx.sv
module test_stx_stream_tx;
  localparam int CNT_W = 16;
  localparam int LEAD  = 8;
  localparam int NVEC  = 8;
  localparam int DEPTH = 64;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0, stream_mode = 1'b0, auto_stop_en = 1'b0, stop_end = 1'b0;
  logic [CNT_W-1:0] byte_count = '0;
  logic hold = 1'b0, fifo_clr = 1'b0;
  int   rd = 0;
  logic fifo_pop, card_clk_en, dat_out, stop_load, busy, done;
  logic fifo_empty;
  logic [7:0] fifo_data;

  int tests = 0, fails = 0;
  logic bits [0:1023];

  // {count, auto, gap_at, gap_len, stop_at}
  localparam int VEC [NVEC][5] = '{
    '{0, 0, 0,  0, 20},
    '{0, 0, 12, 20, 40},
    '{3, 1, 0,  0, 0},
    '{4, 1, 10, 25, 0},
    '{1, 1, 0,  0, 0},
    '{2, 0, 0,  0, 0},
    '{6, 1, 0,  0, 12},
    '{0, 1, 0,  0, 9}
  };

  always #5 clk = ~clk;

  function automatic logic [7:0] byte_at(int i);
    return 8'(i * 37 + 5);
  endfunction

  assign fifo_empty = hold || (rd >= DEPTH);
  assign fifo_data  = byte_at(rd);

  always @(posedge clk) begin
    if (fifo_clr) rd <= 0;
    else if (fifo_pop) rd <= rd + 1;
  end

  stx_stream_tx #(.CNT_W(CNT_W), .BYTE_W(8), .STOP_LEAD(LEAD)) i_stx_stream_tx (
    .clk(clk), .rst(rst), .start(start), .stream_mode(stream_mode),
    .byte_count(byte_count), .auto_stop_en(auto_stop_en),
    .fifo_empty(fifo_empty), .fifo_data(fifo_data), .stop_end(stop_end),
    .fifo_pop(fifo_pop), .card_clk_en(card_clk_en), .dat_out(dat_out),
    .stop_load(stop_load), .busy(busy), .done(done)
  );

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic run_vec(input int cnt, input int au, input int gap_at,
                         input int gap_len, input int stop_at, input int restart);
    int nb = 0, sl_cnt = 0, sl_at = -1, gap_cnt = 0, low_cnt = 0;
    int post = 0, exh_err = 0, mism = 0, exp_bits, done_seen = 0, busy_done = 1;
    bit stop_sent = 0, gap_done = 0, rs_done = 0;
    @(negedge clk);
    fifo_clr = 1; byte_count = CNT_W'(cnt); auto_stop_en = au[0];
    @(negedge clk);
    fifo_clr = 0; start = 1; stream_mode = 1;
    @(negedge clk);
    start = 0;
    for (int c = 0; c < 4000; c++) begin
      if (cnt != 0 && stop_at == 0 && nb == cnt * 8) begin
        if (card_clk_en) exh_err++;
        post++;
      end
      if (card_clk_en) begin bits[nb] = dat_out; nb++; end
      if (stop_load) begin sl_cnt++; sl_at = nb; end
      if (done) begin done_seen = 1; busy_done = busy; break; end
      if (stop_end) stop_end = 0;
      else if (!stop_sent && ((stop_at != 0 && nb >= stop_at) ||
               (stop_at == 0 && cnt != 0 && post >= 3))) begin
        stop_end = 1; stop_sent = 1;
      end
      if (gap_len != 0 && !gap_done && nb >= gap_at) begin
        hold = 1; gap_cnt++;
        if (!card_clk_en) low_cnt++;
        if (gap_cnt == gap_len) begin hold = 0; gap_done = 1; end
      end
      if (restart != 0 && nb == 4 && !rs_done) begin
        start = 1; byte_count = CNT_W'(5); rs_done = 1;
      end else start = 0;
      @(negedge clk);
    end
    hold = 0; stop_end = 0; start = 0;
    exp_bits = (stop_at != 0) ? stop_at + 2 : cnt * 8;
    check("R4 done pulse seen", done_seen, 1);
    check("R4 busy low at done", int'(busy_done), 0);
    check("R2/R4 bit count", nb, exp_bits);
    for (int k = 0; k < nb; k++)
      if (bits[k] != byte_at(k / 8)[7 - (k % 8)]) mism++;
    check("R2/R3 bit stream match", mism, 0);
    if (cnt != 0 && au != 0 && stop_at == 0) begin
      check("R6 stop_load count", sl_cnt, 1);
      check("R6 stop_load position", sl_at, (cnt * 8 > LEAD) ? cnt * 8 - LEAD : 0);
    end else begin
      check("R7 no stop_load", sl_cnt, 0);
    end
    if (cnt != 0 && stop_at == 0) begin
      check("R5 bytes read", rd, cnt);
      check("R5 clock low after last bit", exh_err, 0);
    end
    if (cnt != 0 && stop_at != 0)
      check("R8 early stop bytes read", rd, (stop_at + 7) / 8 + 0);
    if (gap_len != 0)
      check("R3 clock gated in gap", int'(low_cnt >= gap_len - 8), 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++; tests++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R9 reset busy", int'(busy), 0);
    check("R9 reset outputs", int'({done, card_clk_en, stop_load, fifo_pop}), 0);
    rst = 0;
    @(negedge clk);
    // R1: start with stream_mode low
    fifo_clr = 1; @(negedge clk); fifo_clr = 0;
    stream_mode = 0; start = 1; @(negedge clk); start = 0;
    repeat (4) @(negedge clk);
    check("R1 busy stays low", int'(busy), 0);
    check("R1 nothing read", rd, 0);
    for (int v = 0; v < NVEC; v++)
      run_vec(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3], VEC[v][4], 0);
    // R9: start while busy ignored, count stays 2
    run_vec(2, 0, 0, 0, 0, 1);
    repeat (3) @(negedge clk);
    check("R9 idle after restart test", int'(busy), 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule